// File: doc/BRIEF.md
# Control-Pin Mode Decoder with Qualified Sleep Entry

This block turns three static control pins into the internal enables of a line-signalling receiver. Those enables cover two FSK data modes (a raw bit stream, or a one-byte buffered read-out), dual-tone alert detection on either the hybrid input or the line input, a sleep state, and a reserved factory-test state. It also drives three further outputs: the analog input select, the select for the shared ready/steering output, and a sleep flag. While the sleep flag is high, the output stage parks the data, ready/steering and carrier outputs high, and parks the early-steer and guard outputs low.

Every pin passes through a two-flop synchroniser. A code must then hold steady for `SETTLE_CYCLES` clocks before it takes effect. The sleep code is treated differently. It only puts the block to sleep after it has held for `PD_QUAL_CYCLES`, which is 1 ms of the clock by default. If the sleep code is seen for a shorter time, the block does not sleep. Instead, once the code moves away, the block issues one internal reset pulse `PULSE_CYCLES` clocks long. The enables in force before that brief visit stay unchanged throughout.

Top module: `mode_decoder`

## Requirements
- R1: While and after reset (with the sleep code 1,0,0 on the pins), `sleep` is 1, all functional enables and `test_flag` are 0, and `soft_reset` is 0.
- R2: Pin code (mode,sel_a,sel_b) = 0,1,1 gives `fsk_en`=1, `fsk_byte_mode`=0, `tone_en`=0, `tone_src_hybrid`=0 (line input) and `share_ready_sel`=1 (the shared output carries data-ready).
- R3: Code 1,1,1 gives the same outputs as R2 except `fsk_byte_mode`=1.
- R4: Code x,1,0 gives `tone_en`=1 and `tone_src_hybrid`=1. FSK is off and `share_ready_sel`=0 (the shared output carries steering).
- R5: Code x,0,1 gives `tone_en`=1 and `tone_src_hybrid`=0. FSK is off and `share_ready_sel`=0.
- R6: `fsk_en` and `tone_en` are never 1 together.
- R7: Code 0,0,0 gives `test_flag`=1, with every functional enable 0 and `sleep`=0.
- R8: Code 1,0,0 held on the pins sets `sleep` exactly PD_QUAL_CYCLES+3 clocks after it is applied. While asleep, every enable and `test_flag` are 0.
- R9: Code 1,0,0 that lasts from 1 clock up to less than PD_QUAL_CYCLES, while awake, produces exactly one `soft_reset` pulse of PULSE_CYCLES clocks once the code leaves. `sleep` stays 0 and the enables stay as they were.
- R10: A new code lasting SETTLE_CYCLES-1 clocks or fewer changes no output.
- R11: From sleep, a non-sleep code that settles clears `sleep` and applies that code's enables, with no `soft_reset` pulse.
- R12: A non-sleep code change shows on the outputs exactly SETTLE_CYCLES+3 clocks after it is applied to the pins, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_mode | input | 1 | Control pin: interface-mode / sleep qualifier bit |
| pin_sel_a | input | 1 | Control pin: function select, upper bit |
| pin_sel_b | input | 1 | Control pin: function select, lower bit |
| fsk_en | output | 1 | FSK demodulation path enabled (tone detector off) |
| fsk_byte_mode | output | 1 | FSK output through the one-byte buffer rather than raw stream |
| tone_en | output | 1 | Dual-tone alert detector enabled (FSK path off) |
| tone_src_hybrid | output | 1 | Analog input select: 1 hybrid input, 0 line input |
| share_ready_sel | output | 1 | Shared output mux: 1 data-ready, 0 tone steering |
| test_flag | output | 1 | Reserved factory-test code active |
| sleep | output | 1 | Sleep state; parks outputs at their idle levels |
| soft_reset | output | 1 | One-shot internal reset after a brief sleep-code visit |

## Verification
A settled code change reaches the enables three registers plus the settle window after the pins move. The bench therefore drives pins on a falling edge and samples SETTLE_CYCLES+2 falling edges later, where it expects the old value, and one edge after that, where it expects the new one. Sleep entry is sampled the same way at PD_QUAL_CYCLES+2 and +3 edges. A reset pulse appears three clocks after the sleep code leaves, so pulse length and glitch rejection are measured by counting cycles over a fixed window that covers the whole pulse.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

    typedef struct packed {
        logic mode;
        logic sel_a;
        logic sel_b;
    } ctl_code_t;

    localparam ctl_code_t CODE_SLEEP = '{mode: 1'b1, sel_a: 1'b0, sel_b: 1'b0};

    typedef enum logic [2:0] {
        F_FSK_STREAM,
        F_FSK_BYTE,
        F_TONE_HYB,
        F_TONE_LINE,
        F_SLEEP,
        F_TEST
    } func_t;

    typedef struct packed {
        logic fsk_en;
        logic fsk_byte;
        logic tone_en;
        logic tone_hybrid;
        logic share_ready;
        logic test_flag;
    } enables_t;

    function automatic func_t classify(ctl_code_t c);
        func_t f;
        case ({c.sel_a, c.sel_b})
            2'b11:   f = c.mode ? F_FSK_BYTE : F_FSK_STREAM;
            2'b10:   f = F_TONE_HYB;
            2'b01:   f = F_TONE_LINE;
            default: f = c.mode ? F_SLEEP : F_TEST;
        endcase
        return f;
    endfunction

    function automatic enables_t enables_of(func_t f);
        enables_t e;
        e = '0;
        case (f)
            F_FSK_STREAM: begin e.fsk_en = 1'b1; e.share_ready = 1'b1; end
            F_FSK_BYTE: begin
                e.fsk_en      = 1'b1;
                e.fsk_byte    = 1'b1;
                e.share_ready = 1'b1;
            end
            F_TONE_HYB:  begin e.tone_en = 1'b1; e.tone_hybrid = 1'b1; end
            F_TONE_LINE: e.tone_en = 1'b1;
            F_TEST:      e.test_flag = 1'b1;
            default:     e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/mdec_sync.sv
module mdec_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/mdec_qualify.sv
module mdec_qualify
    import mdec_pkg::*;
#(
    parameter int SETTLE_CYCLES  = 8,
    parameter int PD_QUAL_CYCLES = 3579,
    parameter int PULSE_CYCLES   = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  ctl_code_t code_s,
    output ctl_code_t applied,
    output logic      sleep,
    output logic      soft_reset
);
    localparam int AGE_MAX = (PD_QUAL_CYCLES > SETTLE_CYCLES) ? PD_QUAL_CYCLES : SETTLE_CYCLES;
    localparam int AGE_W   = $clog2(AGE_MAX + 1);
    localparam int PW      = $clog2(PULSE_CYCLES + 1);

    ctl_code_t        cand;
    logic [AGE_W-1:0] age;
    logic [PW-1:0]    pcnt;
    logic             changed, settled, pd_done, cand_is_pd;

    assign changed    = (code_s != cand);
    assign cand_is_pd = (cand == CODE_SLEEP);
    assign settled    = (age >= AGE_W'(SETTLE_CYCLES - 1));
    assign pd_done    = (age >= AGE_W'(PD_QUAL_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cand    <= CODE_SLEEP;
            age     <= '0;
            applied <= '0;
            sleep   <= 1'b1;
            pcnt    <= '0;
        end else begin
            if (changed) begin
                cand <= code_s;
                age  <= '0;
            end else if (age != AGE_W'(AGE_MAX)) begin
                age <= age + 1'b1;
            end

            if (!changed && !cand_is_pd && settled) begin
                applied <= cand;
                sleep   <= 1'b0;
            end else if (!changed && cand_is_pd && pd_done) begin
                sleep <= 1'b1;
            end

            if (changed && cand_is_pd && !sleep)
                pcnt <= PW'(PULSE_CYCLES);
            else if (pcnt != '0)
                pcnt <= pcnt - 1'b1;
        end
    end

    assign soft_reset = (pcnt != '0);

    // R9: a started pulse lasts beyond its first cycle
    p_pulse_hold_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(soft_reset) |=> soft_reset)
        else $error("reset pulse shorter than two cycles");

    // R11: leaving sleep issues no reset pulse
    p_wake_clean_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(sleep) |-> !soft_reset)
        else $error("reset pulse at wake-up");

    // R8: sleep is only entered while the sleep code is on the synchronised pins
    p_sleep_code_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep) |-> $past(code_s) == CODE_SLEEP)
        else $error("sleep entered without sleep code");
endmodule

// File: rtl/mdec_decode.sv
module mdec_decode
    import mdec_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ctl_code_t applied,
    input  logic      sleep,
    output enables_t  en
);
    always_comb begin
        if (sleep) en = '0;
        else       en = enables_of(classify(applied));
    end

    // R6: FSK path and tone detector are mutually exclusive
    p_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(en.fsk_en && en.tone_en))
        else $error("fsk and tone enabled together");
endmodule

// File: rtl/mode_decoder.sv
module mode_decoder
    import mdec_pkg::*;
#(
    parameter int CLK_HZ         = 3_579_545,
    parameter int SYNC_STAGES    = 2,
    parameter int SETTLE_CYCLES  = 8,
    parameter int PD_QUAL_CYCLES = CLK_HZ / 1000,
    parameter int PULSE_CYCLES   = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_mode,
    input  logic pin_sel_a,
    input  logic pin_sel_b,
    output logic fsk_en,
    output logic fsk_byte_mode,
    output logic tone_en,
    output logic tone_src_hybrid,
    output logic share_ready_sel,
    output logic test_flag,
    output logic sleep,
    output logic soft_reset
);
    localparam int CODE_W = $bits(ctl_code_t);

    ctl_code_t raw_code, code_s, applied;
    enables_t  en;
    logic [CODE_W-1:0] code_s_bits;

    assign raw_code = '{mode: pin_mode, sel_a: pin_sel_a, sel_b: pin_sel_b};

    mdec_sync #(
        .WIDTH   (CODE_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CODE_SLEEP)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_code),
        .dout (code_s_bits)
    );
    assign code_s = ctl_code_t'(code_s_bits);

    mdec_qualify #(
        .SETTLE_CYCLES  (SETTLE_CYCLES),
        .PD_QUAL_CYCLES (PD_QUAL_CYCLES),
        .PULSE_CYCLES   (PULSE_CYCLES)
    ) u_qual (
        .clk        (clk),
        .rst        (rst),
        .code_s     (code_s),
        .applied    (applied),
        .sleep      (sleep),
        .soft_reset (soft_reset)
    );

    mdec_decode u_dec (
        .clk     (clk),
        .rst     (rst),
        .applied (applied),
        .sleep   (sleep),
        .en      (en)
    );

    assign fsk_en          = en.fsk_en;
    assign fsk_byte_mode   = en.fsk_byte;
    assign tone_en         = en.tone_en;
    assign tone_src_hybrid = en.tone_hybrid;
    assign share_ready_sel = en.share_ready;
    assign test_flag       = en.test_flag;

    // R8: asleep means every enable is off
    p_sleep_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !(fsk_en || tone_en || test_flag || share_ready_sel))
        else $error("enable active in sleep");

    // R7: the test flag stands alone
    p_test_alone_r7: assert property (@(posedge clk) disable iff (rst)
        test_flag |-> !(fsk_en || tone_en || sleep))
        else $error("test flag with other state");

    // R4: the hybrid input is only selected for tone detection
    p_hybrid_tone_r4: assert property (@(posedge clk) disable iff (rst)
        tone_src_hybrid |-> tone_en)
        else $error("hybrid input selected without tone detect");
endmodule

// File: tb/mode_decoder_test.sv
`timescale 1ns/1ps
module mode_decoder_test;
    localparam int SET = 4;
    localparam int PDQ = 40;
    localparam int PUL = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin_mode = 1'b1, pin_sel_a = 1'b0, pin_sel_b = 1'b0;
    logic fsk_en, fsk_byte_mode, tone_en, tone_src_hybrid, share_ready_sel;
    logic test_flag, sleep, soft_reset;
    int   nchk = 0, nerr = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    mode_decoder #(
        .SETTLE_CYCLES  (SET),
        .PD_QUAL_CYCLES (PDQ),
        .PULSE_CYCLES   (PUL)
    ) uut (
        .clk(clk), .rst(rst),
        .pin_mode(pin_mode), .pin_sel_a(pin_sel_a), .pin_sel_b(pin_sel_b),
        .fsk_en(fsk_en), .fsk_byte_mode(fsk_byte_mode), .tone_en(tone_en),
        .tone_src_hybrid(tone_src_hybrid), .share_ready_sel(share_ready_sel),
        .test_flag(test_flag), .sleep(sleep), .soft_reset(soft_reset)
    );

    // vector order: sleep,test,fsk,byte,tone,hybrid,ready ; code order: mode,sel_a,sel_b
    function automatic logic [6:0] expect_of(logic [2:0] c);
        logic m, a, b;
        {m, a, b} = c;
        return {1'b0, ~m & ~a & ~b, a & b, m & a & b, a ^ b, a & ~b, a & b};
    endfunction

    function automatic logic [6:0] obs();
        return {sleep, test_flag, fsk_en, fsk_byte_mode, tone_en, tone_src_hybrid, share_ready_sel};
    endfunction

    function automatic string req_of(logic [2:0] c);
        case (c)
            3'b011:          return "R2";
            3'b111:          return "R3";
            3'b010, 3'b110:  return "R4";
            3'b001, 3'b101:  return "R5";
            default:         return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic [2:0] c);
        @(negedge clk);
        {pin_mode, pin_sel_a, pin_sel_b} = c;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic watch(input int n, input logic [6:0] ex, output int pulses, output int mism);
        pulses = 0;
        mism   = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (soft_reset) pulses++;
            if (obs() !== ex) mism++;
        end
    endtask

    initial begin : watchdog
        #2_000_000;
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin : main
        int p, mm;
        tick(3);
        check("R1 reset vec", {25'd0, obs()}, 32'h40);
        check("R1 reset pulse", {31'd0, soft_reset}, 0);
        @(negedge clk) rst = 1'b0;
        tick(SET + 6);
        check("R1 after release", {25'd0, obs()}, 32'h40);

        // R11: wake from sleep
        drive(3'b011);
        watch(SET + 6, 7'bx, p, mm);
        check("R11 wake vec", {25'd0, obs()}, {25'd0, expect_of(3'b011)});
        check("R11 wake no pulse", p, 0);

        // R12 and R2..R7: sweep all non-sleep code transitions
        for (int fa = 0; fa < 8; fa++) begin
            for (int fb = 0; fb < 8; fb++) begin
                if (fa == 4 || fb == 4) continue;
                drive(3'(fa));
                tick(SET + 4);
                drive(3'(fb));
                tick(SET + 2);
                check("R12 not early", {25'd0, obs()}, {25'd0, expect_of(3'(fa))});
                tick(1);
                check(req_of(3'(fb)), {25'd0, obs()}, {25'd0, expect_of(3'(fb))});
                check("R6 exclusive", {31'd0, fsk_en & tone_en}, 0);
            end
        end

        // R10: short glitches are ignored
        drive(3'b101);
        tick(SET + 4);
        drive(3'b110);
        tick(SET - 2);
        drive(3'b101);
        watch(20, expect_of(3'b101), p, mm);
        check("R10 glitch outputs", mm, 0);
        check("R10 glitch pulse", p, 0);
        drive(3'b000);
        tick(SET - 2);
        drive(3'b101);
        watch(20, expect_of(3'b101), p, mm);
        check("R10 glitch to test", mm, 0);

        // R9: brief sleep code yields one pulse
        drive(3'b111);
        tick(SET + 4);
        drive(3'b100);
        tick(10);
        drive(3'b111);
        watch(40, expect_of(3'b111), p, mm);
        check("R9 pulse length", p, PUL);
        check("R9 state held", mm, 0);
        drive(3'b100);
        drive(3'b111);
        watch(40, expect_of(3'b111), p, mm);
        check("R9 one-cycle pulse", p, PUL);
        check("R9 one-cycle held", mm, 0);

        // R8: held sleep code enters sleep at exactly PDQ+3 edges
        drive(3'b011);
        tick(SET + 4);
        drive(3'b100);
        watch(PDQ + 2, expect_of(3'b011), p, mm);
        check("R8 not early", mm, 0);
        tick(1);
        check("R8 asleep vec", {25'd0, obs()}, 32'h40);
        watch(10, 7'h40, p, mm);
        check("R8 stays asleep", mm, 0);
        check("R8 no pulse", p, 0);

        // R11: wake into buffered FSK
        drive(3'b111);
        tick(SET + 3);
        check("R11 wake byte mode", {25'd0, obs()}, {25'd0, expect_of(3'b111)});
        watch(30, expect_of(3'b111), p, mm);
        check("R11 no pulse", p, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule